// File: doc/BRIEF.md
# Pipelined ADC Digital Error Correction

This block sits behind the analog half of an eleven-stage pipelined converter and turns the stage decisions into one 12-bit sample. It runs on a sub-clock at twice the sample rate. Each stage hands over a 2-bit decision. The first ten stages are redundant 1.5-bit stages. The last stage is a full 2-bit flash. A sample marker input flags the sub-clock cycle in which the track-and-hold takes a sample. Stage n then delivers its decision for that sample n sub-cycles later.

Every stage lane has its own register chain. The chain is one register shorter for each later stage, so all eleven decisions for one sample meet in the same cycle. The decisions are then added with a one-bit overlap between neighbouring stages. Comparator offsets in the redundant stages are absorbed by this overlap. The sum is clamped to the 12-bit range and registered. The output can show offset binary or two's complement. A drive-enable output lets the pad ring float the data lines.

Top module: `adc_pipe_corrector`

## Requirements
- R1: While `rst_n` is low, and after it is released, `out_vld` is 0 and the held sample is 0. With `msb_inv` and `hiz_req` low, `dout` therefore reads 0 and `dout_oe` reads 1. No sample marked before reset ever appears afterwards.
- R2: `samp_ph` is high in the cycle a sample is taken, and never in two cycles in a row. The decision of stage n (n = 1..11) for that sample is on `stg_code[2n-1:2n-2]` in the sub-cycle n cycles after the marker cycle. Codes in all other cycles never affect any sample.
- R3: `out_vld` is high for exactly one sub-cycle, 13 sub-cycles after the marker cycle. `dout` shows that sample from that cycle on. It holds until the next valid cycle.
- R4: With decisions c1..c10 in {0,1,2} and flash code c11 in {0..3}, the sample equals the sum of c_n·2^(11-n) for n = 1..10, plus c11.
- R5: A code of 3 from any of stages 1..10 is treated as 2.
- R6: Let the input fraction x lie in [0,1). Each redundant stage compares its residue against nominal thresholds of 3/8 and 5/8 of its span. If each threshold is off by no more than 1/8 of that span, the sample equals floor(x·4096).
- R7: An input above full scale gives 4095 (all ones, offset binary), and one below zero gives 0. The value never wraps to the opposite end.
- R8: With `msb_inv` low, `dout` is offset binary, so midscale reads 2048. With `msb_inv` high, only bit 11 is inverted, giving two's complement: midscale reads 0 and full scale reads 2047. The change shows on `dout` in the same cycle.
- R9: While `hiz_req` is high, `dout_oe` is 0 and `dout` is all zeros. While it is low, `dout_oe` is 1.
- R10: A ramp across the whole input range with offset stages produces every code from 0 to 4095 in order, each exactly one above the one before.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sub-clock, twice the sample rate |
| rst_n | input | 1 | Asynchronous active-low reset |
| samp_ph | input | 1 | High in the sub-cycle a sample is taken |
| stg_code | input | 22 | Stage decisions, stage n on bits 2n-1:2n-2 |
| msb_inv | input | 1 | High selects two's complement output |
| hiz_req | input | 1 | High floats the data lines |
| dout | output | 12 | Corrected sample |
| dout_oe | output | 1 | Drive enable for the data pads |
| out_vld | output | 1 | One-cycle pulse when a new sample is shown |

## Verification
The checks assume that sample markers come no closer than every second sub-cycle. They also assume that the output controls stay put in any cycle where a new sample lands. The stimulus honours both. It places markers either 15 cycles apart or on alternate cycles, and it changes `msb_inv` and `hiz_req` only between samples. The stage decisions come from a bench model of the analog stages. That model injects threshold offsets up to 1/8 of a stage span, and it feeds junk codes in the cycles that belong to no sample. A correct design therefore meets the assertions only if the per-stage alignment is exact.

// File: rtl/adcec_pkg.sv
package adcec_pkg;

   // Width of one stage decision
   localparam int unsigned STG_CODE_W = 2;

   // Largest legal decision of a redundant (1.5-bit) stage
   localparam logic [STG_CODE_W-1:0] RED_CODE_MAX = 2'd2;

   typedef logic [STG_CODE_W-1:0] stg_code_t;

   // Register count of the alignment lane for stage index idx (0-based).
   // Stage idx reports idx+1 cycles after the marker; all lanes must meet
   // num_stages+1 cycles after it.
   function automatic int unsigned lane_depth(input int unsigned num_stages,
                                              input int unsigned idx);
      return num_stages - idx;
   endfunction

endpackage

// File: rtl/adcec_skew_line.sv
module adcec_skew_line #(
   parameter int unsigned W     = 2,
   parameter int unsigned DEPTH = 1
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);

   if (W < 1) begin : g_bad_width
      $error("adcec_skew_line: W must be at least 1");
   end
   if (DEPTH < 1) begin : g_bad_depth
      $error("adcec_skew_line: DEPTH must be at least 1");
   end

   if (DEPTH == 1) begin : g_single
      logic [W-1:0] r_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) r_q <= '0;
         else        r_q <= d;
      end
      assign q = r_q;
   end else begin : g_chain
      logic [W-1:0] tap [DEPTH];
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) tap[i] <= '0;
         end else begin
            tap[0] <= d;
            for (int i = 1; i < DEPTH; i++) tap[i] <= tap[i-1];
         end
      end
      assign q = tap[DEPTH-1];
   end

endmodule

// File: rtl/adcec_overlap_add.sv
module adcec_overlap_add
   import adcec_pkg::*;
#(
   parameter int unsigned NUM_STAGES = 11
) (
   input  logic [NUM_STAGES*STG_CODE_W-1:0] codes,
   output logic [NUM_STAGES:0]              sum
);

   localparam int unsigned OUT_W = NUM_STAGES + 1;
   localparam int unsigned ACC_W = OUT_W + 1;
   localparam logic [ACC_W-1:0] FULL_SCALE = ACC_W'((64'd1 << OUT_W) - 64'd1);

   logic [ACC_W-1:0] term [NUM_STAGES];
   logic [ACC_W-1:0] acc;

   for (genvar k = 0; k < NUM_STAGES; k++) begin : g_term
      stg_code_t raw;
      assign raw = codes[k*STG_CODE_W +: STG_CODE_W];
      if (k < NUM_STAGES - 1) begin : g_redundant
         // 1.5-bit stage: illegal top code folds onto the largest legal one,
         // weight overlaps the next stage by one bit
         stg_code_t dig;
         assign dig     = (raw > RED_CODE_MAX) ? RED_CODE_MAX : raw;
         assign term[k] = ACC_W'(dig) << (NUM_STAGES - 1 - k);
      end else begin : g_flash
         // final full 2-bit flash, unit weight
         assign term[k] = ACC_W'(raw);
      end
   end

   always_comb begin
      acc = '0;
      for (int k = 0; k < NUM_STAGES; k++) acc = acc + term[k];
      if (acc > FULL_SCALE) sum = FULL_SCALE[OUT_W-1:0];
      else                  sum = acc[OUT_W-1:0];
   end

endmodule

// File: rtl/adcec_out_stage.sv
module adcec_out_stage #(
   parameter int unsigned W = 12
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         load,
   input  logic [W-1:0] din,
   input  logic         msb_inv,
   input  logic         hiz_req,
   output logic [W-1:0] dout,
   output logic         dout_oe,
   output logic         out_vld
);

   if (W < 2) begin : g_bad_width
      $error("adcec_out_stage: W must be at least 2");
   end

   logic [W-1:0] q;
   logic         vld_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         q     <= '0;
         vld_q <= 1'b0;
      end else begin
         vld_q <= load;
         if (load) q <= din;
      end
   end

   assign out_vld = vld_q;
   assign dout_oe = ~hiz_req;
   assign dout    = hiz_req ? '0 : {q[W-1] ^ msb_inv, q[W-2:0]};

endmodule

// File: rtl/adc_pipe_corrector.sv
module adc_pipe_corrector
   import adcec_pkg::*;
#(
   parameter int unsigned NUM_STAGES = 11
) (
   input  logic                             clk,
   input  logic                             rst_n,
   input  logic                             samp_ph,
   input  logic [NUM_STAGES*STG_CODE_W-1:0] stg_code,
   input  logic                             msb_inv,
   input  logic                             hiz_req,
   output logic [NUM_STAGES:0]              dout,
   output logic                             dout_oe,
   output logic                             out_vld
);

   localparam int unsigned OUT_W   = NUM_STAGES + 1;
   localparam int unsigned LAT     = NUM_STAGES + 2;
   localparam int unsigned MARK_DL = LAT - 1;

   if (NUM_STAGES < 2 || NUM_STAGES > 30) begin : g_bad_stages
      $error("adc_pipe_corrector: NUM_STAGES must lie in 2..30");
   end

   logic [NUM_STAGES*STG_CODE_W-1:0] aligned;
   logic                             mark_aligned;
   logic [OUT_W-1:0]                 corr;

   // one alignment lane per stage, shorter for later stages
   for (genvar k = 0; k < NUM_STAGES; k++) begin : g_lane
      adcec_skew_line #(
         .W     (STG_CODE_W),
         .DEPTH (lane_depth(NUM_STAGES, k))
      ) u_line (
         .clk   (clk),
         .rst_n (rst_n),
         .d     (stg_code[k*STG_CODE_W +: STG_CODE_W]),
         .q     (aligned[k*STG_CODE_W +: STG_CODE_W])
      );
   end

   // marker travels alongside the codes
   adcec_skew_line #(
      .W     (1),
      .DEPTH (MARK_DL)
   ) u_mark (
      .clk   (clk),
      .rst_n (rst_n),
      .d     (samp_ph),
      .q     (mark_aligned)
   );

   adcec_overlap_add #(
      .NUM_STAGES (NUM_STAGES)
   ) u_add (
      .codes (aligned),
      .sum   (corr)
   );

   adcec_out_stage #(
      .W (OUT_W)
   ) u_out (
      .clk     (clk),
      .rst_n   (rst_n),
      .load    (mark_aligned),
      .din     (corr),
      .msb_inv (msb_inv),
      .hiz_req (hiz_req),
      .dout    (dout),
      .dout_oe (dout_oe),
      .out_vld (out_vld)
   );

endmodule

// File: rtl/adcec_checker.sv
module adcec_checker #(
   parameter int unsigned NUM_STAGES = 11
) (
   input logic              clk,
   input logic              rst_n,
   input logic              samp_ph,
   input logic              msb_inv,
   input logic              hiz_req,
   input logic [NUM_STAGES:0] dout,
   input logic              dout_oe,
   input logic              out_vld
);

   localparam int unsigned LAT = NUM_STAGES + 2;

   // shadow of marker history, independent of the design's lanes
   logic [LAT-1:0] ph_hist;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) ph_hist <= '0;
      else        ph_hist <= {ph_hist[LAT-2:0], samp_ph};
   end

   // R2: markers never on adjacent sub-cycles
   assert_mark_spacing_R2: assert property (@(posedge clk) disable iff (!rst_n)
      samp_ph |=> !samp_ph);

   // R3: valid pulse exactly LAT sub-cycles after the marker
   assert_latency_R3: assert property (@(posedge clk) disable iff (!rst_n)
      out_vld == ph_hist[LAT-1]);

   // R3: valid is a single-cycle pulse
   assert_vld_pulse_R3: assert property (@(posedge clk) disable iff (!rst_n)
      out_vld |=> !out_vld);

   // R3: data holds between samples while the output controls are steady
   assert_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (!out_vld && $stable(msb_inv) && $stable(hiz_req)) |-> $stable(dout));

   // R8: flipping the format control flips only the top bit
   assert_msb_flip_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (!out_vld && !hiz_req && $stable(hiz_req) && !$stable(msb_inv))
         |-> (dout[NUM_STAGES] != $past(dout[NUM_STAGES]) &&
              dout[NUM_STAGES-1:0] == $past(dout[NUM_STAGES-1:0])));

   // R9: floated output carries no data and no drive
   assert_float_R9: assert property (@(posedge clk) disable iff (!rst_n)
      hiz_req |-> (dout == '0 && !dout_oe));

endmodule

bind adc_pipe_corrector adcec_checker #(.NUM_STAGES(NUM_STAGES)) u_chk (
   .clk     (clk),
   .rst_n   (rst_n),
   .samp_ph (samp_ph),
   .msb_inv (msb_inv),
   .hiz_req (hiz_req),
   .dout    (dout),
   .dout_oe (dout_oe),
   .out_vld (out_vld)
);

// File: tb/adc_pipe_corrector_tb.sv
module adc_pipe_corrector_tb;

   localparam int NS  = 11;
   localparam int LAT = 13;
   localparam int NV  = 14;

   // table: input (1/65536 of full scale), offset seed, illegal-3 mask,
   // msb_inv, hiz_req, requirement
   localparam longint TV_X    [NV] = '{0, 65535, 32768, 32768, 65535, 0, 20000,
                                       47000, 65535, 80000, -4000, 200000, 30000, 16383};
   localparam int     TV_SEED [NV] = '{0, 1, 2, 0, 5, 0, 3, 9, 0, 4, 2, 7, 1, 6};
   localparam int     TV_ILL  [NV] = '{0, 0, 0, 0, 0, 0, 0, 1023, 1023, 0, 0, 0, 0, 0};
   localparam bit     TV_INV  [NV] = '{0, 0, 0, 1, 1, 1, 0, 0, 0, 0, 0, 0, 0, 0};
   localparam bit     TV_HIZ  [NV] = '{0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 1, 0};
   localparam int     TV_REQ  [NV] = '{4, 4, 8, 8, 8, 8, 6, 5, 5, 7, 7, 7, 9, 6};

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              samp_ph = 1'b0;
   logic [NS*2-1:0]   stg_code = '0;
   logic              msb_inv = 1'b0;
   logic              hiz_req = 1'b0;
   logic [NS:0]       dout;
   logic              dout_oe;
   logic              out_vld;

   int n_chk = 0;
   int n_bad = 0;
   bit finished = 0;

   logic [NS*2-1:0] cyc_vec [0:NS];
   bit              em [16];
   int              ev [16];
   string           etag [16];
   int              cyc = 0;
   int              held = 0;
   bit              ramp_on = 0;
   int              ramp_prev = -1;
   int              ramp_bad = 0;

   adc_pipe_corrector #(.NUM_STAGES(NS)) u_dut (
      .clk      (clk),
      .rst_n    (rst_n),
      .samp_ph  (samp_ph),
      .stg_code (stg_code),
      .msb_inv  (msb_inv),
      .hiz_req  (hiz_req),
      .dout     (dout),
      .dout_oe  (dout_oe),
      .out_vld  (out_vld)
   );

   always #10 clk = ~clk;

   function automatic string req_name(input int r);
      case (r)
         4: return "R4";
         5: return "R5";
         6: return "R6";
         7: return "R7";
         8: return "R8";
         9: return "R9";
         default: return "R2";
      endcase
   endfunction

   // ideal converter
   function automatic int ideal(input longint x);
      if (x < 0) return 0;
      if (x >= 65536) return 4095;
      return int'(x >>> 4);
   endfunction

   // analog stage model with threshold offsets up to 1/8 of the stage span
   function automatic logic [NS*2-1:0] quantize(input longint x, input int seed, input int ill);
      longint r;
      longint t1;
      longint t2;
      int d;
      logic [NS*2-1:0] v;
      r = x;
      v = '0;
      for (int k = 0; k < NS - 1; k++) begin
         t1 = 24576 + longint'(((((k*7 + seed*5 + 3) % 17) - 8) * 1024));
         t2 = 40960 + longint'(((((k*11 + seed*3 + 5) % 17) - 8) * 1024));
         d = ((r >= t1) ? 1 : 0) + ((r >= t2) ? 1 : 0);
         if (d == 2 && ill[k]) v[2*k +: 2] = 2'd3;
         else                  v[2*k +: 2] = 2'(d);
         r = 2*r - longint'(d) * 32768;
      end
      if (r < 0)           d = 0;
      else if (r >= 65536) d = 3;
      else                 d = int'(r >>> 14);
      v[2*(NS-1) +: 2] = 2'(d);
      return v;
   endfunction

   task automatic chk(input bit ok, input string tag, input longint act, input longint expv);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, expv);
      end
   endtask

   // one sub-cycle: check outputs of this cycle, then drive the next inputs
   task automatic tick(input bit mk, input longint x, input int seed, input int ill,
                       input string tag);
      int idx;
      int expd;
      @(negedge clk);
      idx = (cyc - LAT) & 15;
      chk(out_vld == em[idx], "R3 valid timing", longint'(out_vld), longint'(em[idx]));
      if (em[idx]) held = ev[idx];
      expd = hiz_req ? 0 : (held ^ (msb_inv ? 2048 : 0));
      chk(int'(dout) == expd, em[idx] ? etag[idx] : "R3 hold", longint'(dout), longint'(expd));
      chk(dout_oe == !hiz_req, "R9 drive enable", longint'(dout_oe), longint'(!hiz_req));
      if (em[idx] && ramp_on) begin
         if (int'(dout) != ramp_prev + 1) ramp_bad++;
         ramp_prev = int'(dout);
      end
      for (int j = NS; j >= 1; j--) cyc_vec[j] = cyc_vec[j-1];
      cyc_vec[0] = mk ? quantize(x, seed, ill) : (NS*2)'(cyc * 32'd2654435761);
      em[cyc & 15]   = mk;
      ev[cyc & 15]   = ideal(x);
      etag[cyc & 15] = tag;
      samp_ph = mk;
      for (int k = 0; k < NS; k++) stg_code[2*k +: 2] = cyc_vec[k+1][2*k +: 2];
      cyc++;
   endtask

   task automatic idle(input int n);
      for (int i = 0; i < n; i++) tick(1'b0, 0, 0, 0, "R3");
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst_n = 1'b0;
      samp_ph = 1'b0;
      stg_code = '0;
      msb_inv = 1'b0;
      hiz_req = 1'b0;
      repeat (2) @(negedge clk);
      chk(dout == '0, "R1 reset data", longint'(dout), 0);
      chk(out_vld == 1'b0, "R1 reset valid", longint'(out_vld), 0);
      chk(dout_oe == 1'b1, "R1 reset drive", longint'(dout_oe), 1);
      for (int i = 0; i < 16; i++) begin
         em[i] = 0;
         ev[i] = 0;
         etag[i] = "R1";
      end
      for (int j = 0; j <= NS; j++) cyc_vec[j] = '0;
      held = 0;
      cyc = 0;
      rst_n = 1'b1;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!finished) begin
         n_chk++;
         n_bad++;
         $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 0);
         $display("test done: total=%0d bad=%0d", n_chk, n_bad);
         $finish;
      end
   end

   initial begin
      do_reset();
      idle(3);

      // table walk: one sample per entry, spaced out so controls stay static
      for (int v = 0; v < NV; v++) begin
         @(negedge clk);
         msb_inv = TV_INV[v];
         hiz_req = TV_HIZ[v];
         tick(1'b1, TV_X[v], TV_SEED[v], TV_ILL[v], req_name(TV_REQ[v]));
         idle(LAT + 1);
      end
      msb_inv = 1'b0;
      hiz_req = 1'b0;
      idle(2);

      // R8: toggle format control between samples, output follows at once
      msb_inv = 1'b1;
      idle(2);
      msb_inv = 1'b0;
      idle(2);

      // R9: float and restore between samples
      hiz_req = 1'b1;
      idle(2);
      hiz_req = 1'b0;
      idle(2);

      // R2 R6: back-to-back samples with junk on the unused cycles
      for (int s = 0; s < 40; s++) begin
         tick(1'b1, longint'((s * 7919 + 123) % 65536), s % 11, (s % 3 == 0) ? 341 : 0, "R2 R6");
         tick(1'b0, 0, 0, 0, "R3");
      end
      idle(LAT + 1);

      // R10: full ramp through offset stages
      ramp_on = 1;
      for (int i = 0; i < 4096; i++) begin
         tick(1'b1, longint'(i * 16 + (i % 16)), i % 13, 0, "R10 R6");
         tick(1'b0, 0, 0, 0, "R3");
      end
      idle(LAT + 1);
      ramp_on = 0;
      chk(ramp_bad == 0 && ramp_prev == 4095, "R10 ramp coverage",
          longint'(ramp_bad * 10000 + ramp_prev), 4095);

      // R1: reset with samples in flight drops them
      for (int s = 0; s < 4; s++) begin
         tick(1'b1, 50000, s, 0, "R1");
         tick(1'b0, 0, 0, 0, "R3");
      end
      do_reset();
      idle(LAT + 3);

      // R7: saturation again after reset, streaming
      tick(1'b1, 1000000, 3, 0, "R7");
      tick(1'b0, 0, 0, 0, "R3");
      tick(1'b1, -1000000, 8, 0, "R7");
      idle(LAT + 2);

      finished = 1;
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
   end

endmodule